// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control core of a shadowed memory in which every SRAM word has a nonvolatile twin. It decides when the whole array is copied into nonvolatile storage (a store) and when it is copied back (a recall). It then drives one phase output at a time so the array logic knows what to do. A store is an erase phase followed by a program phase. A recall is a clear phase followed by a transfer phase. Each phase lasts a parameter-set number of reference-clock cycles.

Inputs are two supply comparator levels, a software store request, a software recall request and the SRAM write strobe. The comparator levels are the upper "switch" level and the lower "reset" level. All inputs are assumed to be already synchronous to `clk_i`. Reset (`rst_ni` low) is treated as power-up.

The block decides store or recall as follows:
- A falling supply starts a store only when the array has been written since the last completed cycle.
- A deep supply dip, or power-up, leaves a recall pending until the supply is back above the switch level.
- While a cycle runs, `busy_o` disables SRAM access.
- `wr_inhibit_o` blocks writes while the block is busy and while the supply is below the switch level.

The controller has five states:
- `S_IDLE` is the idle state.
- `S_ERASE` and `S_PROG` make up a store.
- `S_CLEAR` and `S_XFER` make up a recall.

Transitions:
- **auto-store**: `S_IDLE`→`S_ERASE`, taken when the supply is below switch and the write flag is set.
- **pending-recall**: `S_IDLE`→`S_CLEAR`, taken when the supply is above switch and a recall is pending. It uses the long transfer time.
- **sw-store**: `S_IDLE`→`S_ERASE`, taken on a software store request.
- **sw-recall**: `S_IDLE`→`S_CLEAR`, taken on a software recall request. It uses the short transfer time.
- **erase-done**: `S_ERASE`→`S_PROG`.
- **store-done**: `S_PROG`→`S_IDLE`.
- **clear-done**: `S_CLEAR`→`S_XFER`.
- **recall-done**: `S_XFER`→`S_IDLE`.
- **abandon**: `S_CLEAR`/`S_XFER`→`S_IDLE`, taken when the supply falls below switch during a recall.

Top module: `nv_cycle_seq`

## Requirements
- R1: While reset is held and directly after it, no phase output, `phase_start_o` or `busy_o` is high. A recall is pending from reset.
- R2: In idle with the supply below switch, a store (erase then program) starts on the next edge only if an accepted write occurred since the last completed or abandoned cycle. Otherwise the block stays idle.
- R3: An idle software store request with the supply above switch runs a store whether or not any write occurred. Erase lasts ERASE_CYC cycles and program lasts PROG_CYC cycles.
- R4: A recall is a clear phase of CLEAR_CYC cycles and then a transfer phase. The transfer lasts SW_XFER_CYC cycles for a software recall and PU_XFER_CYC cycles for a pending (power-up or dip) recall.
- R5: Reset or the supply below the reset level sets a pending recall. The recall does not start until the supply is above switch. A dip that stays above the reset level causes no recall.
- R6: While the supply is below switch, `wr_inhibit_o` is 1. Writes are not accepted and software store requests are ignored, including a write in the very cycle the supply falls.
- R7: `busy_o` is high in every cycle of a store or recall, together with `wr_inhibit_o`. Software requests and writes that arrive while busy have no effect.
- R8: The write flag is cleared at the end of every store or recall, so a later supply fall without a new write starts no store.
- R9: Exactly one phase output (`erase_o`, `program_o`, `clear_o`, `xfer_o`) is high per busy cycle. `phase_start_o` pulses in its first cycle and `phase_done_o` in its last cycle.
- R10: A supply fall below switch during clear or transfer abandons the recall in the next edge without a done pulse and re-latches the pending recall.
- R11: In idle with the supply above switch, priority is pending recall, then software store, then software recall.
- R12: A store, once started, runs to completion whatever the supply levels do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that times all phases |
| rst_ni | input | 1 | Active-low reset, treated as power-up |
| above_sw_i | input | 1 | Supply is above the switch level |
| above_rst_i | input | 1 | Supply is above the reset level |
| sw_store_i | input | 1 | Software store request |
| sw_recall_i | input | 1 | Software recall request |
| wr_strobe_i | input | 1 | SRAM write strobe, one per write cycle |
| erase_o | output | 1 | Erase phase of a store active |
| program_o | output | 1 | Program phase of a store active |
| clear_o | output | 1 | Clear phase of a recall active |
| xfer_o | output | 1 | Transfer phase of a recall active |
| phase_start_o | output | 1 | First cycle of a phase |
| phase_done_o | output | 1 | Last cycle of a completed phase |
| busy_o | output | 1 | A store or recall is running, SRAM access disabled |
| wr_inhibit_o | output | 1 | SRAM writes are blocked |

## Verification
Two events can fall in the same clock cycle: a write strobe and the supply dropping below the switch level. The bench drives both at one falling edge and then holds the supply low. Judged against R6, the inhibited write must not arm the write flag, so `busy_o` must stay low. A second coincidence is a software store request arriving in the cycle after a pending recall has been latched. It is judged by the scoreboard, which must see the long clear/transfer pair and no erase/program pair.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE,
        S_PROG,
        S_CLEAR,
        S_XFER
    } seq_state_t;
endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Loaded with len-1 so that the last phase cycle sees zero.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done_o = (cnt_q == '0);

    AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(len_i) - CNT_W'(1))); // R9
endmodule

// File: rtl/nvseq_track.sv
module nvseq_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic above_rst_i,
    input  logic wr_ok_i,
    input  logic cyc_end_i,
    input  logic rec_done_i,
    input  logic abandon_i,
    output logic pend_o,
    output logic dirty_o
);
    logic pend_q;
    logic dirty_q;

    // Pending recall: armed by power-up, a deep dip or an abandoned recall.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            pend_q <= 1'b1;
        else if (!above_rst_i || abandon_i)
            pend_q <= 1'b1;
        else if (rec_done_i)
            pend_q <= 1'b0;
    end

    // Write-since-last-cycle flag.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            dirty_q <= 1'b0;
        else if (cyc_end_i)
            dirty_q <= 1'b0;
        else if (wr_ok_i)
            dirty_q <= 1'b1;
    end

    assign pend_o  = pend_q;
    assign dirty_o = dirty_q;

    AST_PEND_ON_DIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !above_rst_i |=> pend_o); // R5
    AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok_i && !cyc_end_i) |=> dirty_o); // R8
    AST_DIRTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_end_i |=> !dirty_o); // R8
endmodule

// File: rtl/nv_cycle_seq.sv
module nv_cycle_seq #(
    parameter int ERASE_CYC   = 40,
    parameter int PROG_CYC    = 60,
    parameter int CLEAR_CYC   = 8,
    parameter int SW_XFER_CYC = 12,
    parameter int PU_XFER_CYC = 30
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic above_sw_i,
    input  logic above_rst_i,
    input  logic sw_store_i,
    input  logic sw_recall_i,
    input  logic wr_strobe_i,
    output logic erase_o,
    output logic program_o,
    output logic clear_o,
    output logic xfer_o,
    output logic phase_start_o,
    output logic phase_done_o,
    output logic busy_o,
    output logic wr_inhibit_o
);
    import nvseq_pkg::*;

    localparam int MAX_ST  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_XF  = (SW_XFER_CYC > PU_XFER_CYC) ? SW_XFER_CYC : PU_XFER_CYC;
    localparam int MAX_RC  = (CLEAR_CYC > MAX_XF) ? CLEAR_CYC : MAX_XF;
    localparam int MAX_ALL = (MAX_ST > MAX_RC) ? MAX_ST : MAX_RC;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    seq_state_t       state_q, state_d;
    logic             long_q, long_d;
    logic             start_q;
    logic             load;
    logic [CNT_W-1:0] load_len;
    logic             tmr_done;
    logic             ph_done;
    logic             abandon;
    logic             rec_done;
    logic             cyc_end;
    logic             wr_ok;
    logic             pend;
    logic             dirty;

    nvseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .len_i  (load_len),
        .done_o (tmr_done)
    );

    nvseq_track u_track (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .above_rst_i (above_rst_i),
        .wr_ok_i     (wr_ok),
        .cyc_end_i   (cyc_end),
        .rec_done_i  (rec_done),
        .abandon_i   (abandon),
        .pend_o      (pend),
        .dirty_o     (dirty)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            long_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            long_q  <= long_d;
            start_q <= load;
        end
    end

    // Next state and phase loading
    always_comb begin
        state_d  = state_q;
        long_d   = long_q;
        load     = 1'b0;
        load_len = '0;
        ph_done  = 1'b0;
        abandon  = 1'b0;
        rec_done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (!above_sw_i) begin
                    if (dirty) begin                       // auto-store
                        state_d  = S_ERASE;
                        load     = 1'b1;
                        load_len = CNT_W'(ERASE_CYC);
                    end
                end else if (pend) begin                   // pending-recall
                    state_d  = S_CLEAR;
                    long_d   = 1'b1;
                    load     = 1'b1;
                    load_len = CNT_W'(CLEAR_CYC);
                end else if (sw_store_i) begin             // sw-store
                    state_d  = S_ERASE;
                    load     = 1'b1;
                    load_len = CNT_W'(ERASE_CYC);
                end else if (sw_recall_i) begin            // sw-recall
                    state_d  = S_CLEAR;
                    long_d   = 1'b0;
                    load     = 1'b1;
                    load_len = CNT_W'(CLEAR_CYC);
                end
            end
            S_ERASE: begin
                if (tmr_done) begin                        // erase-done
                    ph_done  = 1'b1;
                    state_d  = S_PROG;
                    load     = 1'b1;
                    load_len = CNT_W'(PROG_CYC);
                end
            end
            S_PROG: begin
                if (tmr_done) begin                        // store-done
                    ph_done = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_CLEAR: begin
                if (!above_sw_i) begin                     // abandon
                    abandon = 1'b1;
                    state_d = S_IDLE;
                end else if (tmr_done) begin               // clear-done
                    ph_done  = 1'b1;
                    state_d  = S_XFER;
                    load     = 1'b1;
                    load_len = long_q ? CNT_W'(PU_XFER_CYC) : CNT_W'(SW_XFER_CYC);
                end
            end
            S_XFER: begin
                if (!above_sw_i) begin                     // abandon
                    abandon = 1'b1;
                    state_d = S_IDLE;
                end else if (tmr_done) begin               // recall-done
                    ph_done  = 1'b1;
                    rec_done = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign cyc_end = abandon || (ph_done && (state_d == S_IDLE));
    assign wr_ok   = wr_strobe_i && !wr_inhibit_o;

    // Outputs
    always_comb begin
        erase_o       = (state_q == S_ERASE);
        program_o     = (state_q == S_PROG);
        clear_o       = (state_q == S_CLEAR);
        xfer_o        = (state_q == S_XFER);
        busy_o        = (state_q != S_IDLE);
        wr_inhibit_o  = busy_o || !above_sw_i;
        phase_start_o = start_q;
        phase_done_o  = ph_done;
    end

    AST_STORE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(program_o) |-> $past(erase_o)); // R3
    AST_RECALL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xfer_o) |-> $past(clear_o)); // R4
    AST_NO_CLEAN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_IDLE && !above_sw_i && !dirty) |=> (state_q == S_IDLE)); // R2
    AST_NO_RECALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_IDLE && !above_sw_i) |=> !clear_o); // R5
    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_start_o |-> busy_o); // R9
    AST_STORE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (program_o && !tmr_done) |=> program_o); // R12
    AST_ABANDON_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abandon |=> (pend && !busy_o)); // R10
endmodule

// File: tb/nv_cycle_seq_tb_top.sv
module nv_cycle_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int E_LEN  = 40;
    localparam int P_LEN  = 60;
    localparam int C_LEN  = 8;
    localparam int SX_LEN = 12;
    localparam int PX_LEN = 30;
    localparam int PH_ERASE = 1, PH_PROG = 2, PH_CLEAR = 3, PH_XFER = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_sw = 1'b0, above_rst = 1'b0;
    logic sw_store = 1'b0, sw_recall = 1'b0, wr_strobe = 1'b0;
    logic erase, prog, clr, xfer, ph_start, ph_done, busy, wr_inh;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        int    code;
        int    len;
        bit    cut;
        string req;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_cycle_seq #(
        .ERASE_CYC(E_LEN), .PROG_CYC(P_LEN), .CLEAR_CYC(C_LEN),
        .SW_XFER_CYC(SX_LEN), .PU_XFER_CYC(PX_LEN)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .above_sw_i(above_sw), .above_rst_i(above_rst),
        .sw_store_i(sw_store), .sw_recall_i(sw_recall), .wr_strobe_i(wr_strobe),
        .erase_o(erase), .program_o(prog), .clear_o(clr), .xfer_o(xfer),
        .phase_start_o(ph_start), .phase_done_o(ph_done), .busy_o(busy),
        .wr_inhibit_o(wr_inh)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int code, int len, bit cut, string req);
        item_t it;
        it.code = code; it.len = len; it.cut = cut; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (busy && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(!busy, "R7", "cycle did not finish", int'(busy), 0);
    endtask

    task automatic pulse_wr();
        @(negedge clk) wr_strobe = 1'b1;
        @(negedge clk) wr_strobe = 1'b0;
    endtask

    task automatic pulse_store();
        @(negedge clk) sw_store = 1'b1;
        @(negedge clk) sw_store = 1'b0;
    endtask

    task automatic pulse_recall();
        @(negedge clk) sw_recall = 1'b1;
        @(negedge clk) sw_recall = 1'b0;
    endtask

    // Monitor: measures each phase and compares it with the expected queue.
    int ph_code = 0;
    int ph_len  = 0;
    bit in_ph   = 1'b0;

    task automatic compare(int code, int len, bit cut);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected phase code", code, 0);
        end else begin
            it = exp_q.pop_front();
            chk(it.code == code, it.req, "phase code", code, it.code);
            chk(it.len == len, it.req, "phase length", len, it.len);
            chk(it.cut == cut, it.req, "phase abandoned", int'(cut), int'(it.cut));
        end
    endtask

    always @(negedge clk) begin
        int cur;
        if (rst_n) begin
            cur = erase ? PH_ERASE : prog ? PH_PROG : clr ? PH_CLEAR : xfer ? PH_XFER : 0;
            if (ph_start) begin
                in_ph = 1'b1; ph_code = cur; ph_len = 1;
            end else if (in_ph) begin
                if (cur == ph_code) ph_len++;
                else begin
                    compare(ph_code, ph_len, 1'b1);
                    in_ph = 1'b0;
                end
            end
            if (in_ph && ph_done) begin
                compare(ph_code, ph_len, 1'b0);
                in_ph = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R7 watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk(!busy, "R1", "busy in reset", int'(busy), 0);
        chk({erase, prog, clr, xfer, ph_start} == 5'b0, "R1", "phase outputs in reset",
            int'({erase, prog, clr, xfer, ph_start}), 0);
        chk(wr_inh, "R6", "write inhibit below switch", int'(wr_inh), 1);
        @(negedge clk) rst_n = 1'b1;
        cyc(3);
        chk(!busy, "R5", "recall started below switch", int'(busy), 0);
        above_rst = 1'b1;
        cyc(2);
        chk(!busy, "R5", "recall started below switch", int'(busy), 0);
        // power-up recall (R1 pending from reset)
        push(PH_CLEAR, C_LEN, 1'b0, "R1");
        push(PH_XFER, PX_LEN, 1'b0, "R4");
        above_sw = 1'b1;
        cyc(1);
        chk(busy && wr_inh, "R7", "busy and inhibit during recall", int'({busy, wr_inh}), 3);
        wait_idle();
        chk(!wr_inh, "R7", "inhibit after cycle", int'(wr_inh), 0);

        // brown-out without writes: no store, no recall
        above_sw = 1'b0;
        cyc(10);
        chk(!busy, "R2", "store without write", int'(busy), 0);
        above_sw = 1'b1;
        cyc(10);
        chk(!busy, "R5", "recall after shallow dip", int'(busy), 0);

        // write then supply fall: automatic store, runs below switch (R12)
        pulse_wr();
        push(PH_ERASE, E_LEN, 1'b0, "R2");
        push(PH_PROG, P_LEN, 1'b0, "R12");
        above_sw = 1'b0;
        cyc(1);
        chk(busy, "R2", "auto store start", int'(busy), 1);
        wait_idle();
        cyc(10);
        chk(!busy, "R8", "second store after clean", int'(busy), 0);
        above_sw = 1'b1;
        cyc(5);
        chk(!busy, "R5", "recall after shallow dip", int'(busy), 0);

        // software store without writes
        push(PH_ERASE, E_LEN, 1'b0, "R3");
        push(PH_PROG, P_LEN, 1'b0, "R3");
        pulse_store();
        wait_idle();

        // software recall; requests and writes during busy ignored
        push(PH_CLEAR, C_LEN, 1'b0, "R4");
        push(PH_XFER, SX_LEN, 1'b0, "R4");
        pulse_recall();
        cyc(2);
        pulse_store();
        pulse_wr();
        wait_idle();
        cyc(5);
        chk(!busy, "R7", "store request during busy acted", int'(busy), 0);
        above_sw = 1'b0;
        cyc(10);
        chk(!busy, "R7", "write during busy acted", int'(busy), 0);
        above_sw = 1'b1;
        cyc(2);

        // below switch: software store and writes blocked
        above_sw = 1'b0;
        pulse_store();
        cyc(3);
        chk(!busy, "R6", "store request below switch", int'(busy), 0);
        pulse_wr();
        above_sw = 1'b1;
        cyc(3);
        above_sw = 1'b0;
        cyc(10);
        chk(!busy, "R6", "write below switch accepted", int'(busy), 0);
        above_sw = 1'b1;
        cyc(2);

        // coincident write and supply fall
        @(negedge clk) begin wr_strobe = 1'b1; above_sw = 1'b0; end
        @(negedge clk) wr_strobe = 1'b0;
        cyc(10);
        chk(!busy, "R6", "write coincident with supply fall", int'(busy), 0);
        above_sw = 1'b1;
        cyc(2);

        // simultaneous software requests: store wins
        push(PH_ERASE, E_LEN, 1'b0, "R11");
        push(PH_PROG, P_LEN, 1'b0, "R11");
        @(negedge clk) begin sw_store = 1'b1; sw_recall = 1'b1; end
        @(negedge clk) begin sw_store = 1'b0; sw_recall = 1'b0; end
        wait_idle();

        // recall clears the write flag
        pulse_wr();
        push(PH_CLEAR, C_LEN, 1'b0, "R8");
        push(PH_XFER, SX_LEN, 1'b0, "R8");
        pulse_recall();
        wait_idle();
        above_sw = 1'b0;
        cyc(10);
        chk(!busy, "R8", "store after recall without write", int'(busy), 0);

        // deep dip: recall waits for switch level
        above_rst = 1'b0;
        cyc(3);
        above_rst = 1'b1;
        cyc(5);
        chk(!busy, "R5", "recall before switch level", int'(busy), 0);
        push(PH_CLEAR, C_LEN, 1'b0, "R5");
        push(PH_XFER, PX_LEN, 1'b0, "R5");
        above_sw = 1'b1;
        wait_idle();

        // pending recall beats a software store
        @(negedge clk) above_rst = 1'b0;
        @(negedge clk) begin above_rst = 1'b1; sw_store = 1'b1; end
        @(negedge clk) sw_store = 1'b0;
        push(PH_CLEAR, C_LEN, 1'b0, "R11");
        push(PH_XFER, PX_LEN, 1'b0, "R11");
        wait_idle();
        cyc(5);
        chk(!busy, "R11", "store after pending recall", int'(busy), 0);

        // abandoned recall
        push(PH_CLEAR, C_LEN, 1'b0, "R10");
        push(PH_XFER, 5, 1'b1, "R10");
        pulse_recall();
        begin
            int k = 0;
            @(negedge clk);
            while (!(xfer && ph_start) && k < 100) begin
                @(negedge clk);
                k++;
            end
        end
        cyc(4);
        above_sw = 1'b0;
        cyc(1);
        chk(!busy, "R10", "recall not abandoned", int'(busy), 0);
        cyc(5);
        chk(!busy, "R10", "busy after abandon", int'(busy), 0);
        push(PH_CLEAR, C_LEN, 1'b0, "R10");
        push(PH_XFER, PX_LEN, 1'b0, "R10");
        above_sw = 1'b1;
        wait_idle();

        cyc(5);
        chk(exp_q.size() == 0, "R9", "expected phases not seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule